// File: doc/BRIEF.md
# Communication Controller Register File

This block is the register file that a local 16-bit processor on a network communication board sees on its register bus. It holds four transfer descriptors (receive offset, receive size, send offset, send size), two general-purpose status words and a bank select for the shared communication RAM. It also produces the two interrupt requests that start a receive or a send, and it holds the local processor in reset until it is released through a register write.

The bus uses byte offsets and 16-bit data. A write is a one-cycle strobe with an address and data. Read data is combinational from the current address and the registered state. Each descriptor is loaded one byte per write. The byte enters at the top of the register and the previous contents move down by eight bits, so two writes load a full 16-bit value. A transfer starts when the command byte 0x8C is written to the receive or send command offset.

Top module: `commRegs`

## Requirements
- R1: After reset, both status words, the bank select and all descriptors read zero, `rxIrq` and `txIrq` are 0, and `cpuHold` is 1.
- R2: A write to offset 0x16 with data bits [7:0] equal to 0x8C sets `rxIrq`. Any other low byte written to 0x16 clears it, and the upper byte is ignored.
- R3: A write to offset 0x1C with data bits [7:0] equal to 0x8C sets `txIrq`. Any other low byte written to 0x1C clears it, and the upper byte is ignored.
- R4: Descriptors sit at offsets 0x40 (receive offset), 0x42 (receive size), 0x44 (send offset) and 0x46 (send size). A write stores {data[7:0], old[15:8]}, and a read returns the stored value.
- R5: Status word 0 at offset 0x88 and status word 1 at offset 0x8A hold the full 16-bit written value and read it back.
- R6: A write to offset 0xC0 sets `cpuHold` to 1 when all data bits are zero and to 0 otherwise.
- R7: A write to offset 0x60 sets `ramBankHigh` to 1 (upper 64 KB half) when any data bit is set and to 0 (lower half) otherwise. A read of 0x60 returns 0x0001 or 0x0000 to match.
- R8: Reads of any offset other than 0x40, 0x42, 0x44, 0x46, 0x60, 0x88 and 0x8A return 0, odd offsets included. Writes to offsets that are not listed in R2 to R7 change no state.
- R9: `rxIrq`, `txIrq`, `cpuHold` and `ramBankHigh` are registered. Each changes on the clock edge that samples the qualifying write and holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrite | input | 1 | Write strobe, one cycle per write |
| busAddr | input | ADDR_W (8) | Byte offset of the access |
| busWrData | input | DATA_W (16) | Write data |
| busRdData | output | DATA_W (16) | Read data for `busAddr` |
| rxIrq | output | 1 | Receive start interrupt request |
| txIrq | output | 1 | Send start interrupt request |
| cpuHold | output | 1 | Holds the local processor in reset while 1 |
| ramBankHigh | output | 1 | Selects the upper half of the shared RAM |

## Verification
The bench builds the block with its default parameters: an 8-bit offset bus and 16-bit data. With these values every offset in the map is reachable, including the odd offsets next to real registers, and the byte-shift load of a descriptor fills a complete 16-bit value in exactly two writes. Directed writes place the command byte in the upper byte, put data only in the upper bits of the bank and processor-release writes, and hit holes in the map. A random phase then mixes all offsets while a behavioural model is compared on every clock.

// File: rtl/commRegsPkg.sv
package commRegsPkg;

  localparam int NUM_DESC = 4;

  localparam logic [7:0] OFF_RX_CMD    = 8'h16;
  localparam logic [7:0] OFF_TX_CMD    = 8'h1C;
  localparam logic [7:0] OFF_DESC_BASE = 8'h40;
  localparam logic [7:0] OFF_BANK      = 8'h60;
  localparam logic [7:0] OFF_STAT0     = 8'h88;
  localparam logic [7:0] OFF_STAT1     = 8'h8A;
  localparam logic [7:0] OFF_CPU_RST   = 8'hC0;
  localparam logic [7:0] CMD_START     = 8'h8C;

  typedef struct packed {
    logic                rxCmd;
    logic                txCmd;
    logic [NUM_DESC-1:0] desc;
    logic                stat0;
    logic                stat1;
    logic                cpuRst;
    logic                bank;
  } wrStrobes_t;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_DESC,
    RD_STAT0,
    RD_STAT1,
    RD_BANK
  } rdSel_t;

endpackage

// File: rtl/commRegsDecode.sv
module commRegsDecode
  import commRegsPkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int DIDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output wrStrobes_t        strobes,
  output rdSel_t            rdSel,
  output logic [DIDX_W-1:0] descIdx
);

  logic [NUM_DESC-1:0] descMatch;

  for (genvar g = 0; g < NUM_DESC; g++) begin : gDescMatch
    assign descMatch[g] = (busAddr == ADDR_W'(int'(OFF_DESC_BASE) + 2 * g));
  end

  logic hitRx, hitTx, hitStat0, hitStat1, hitCpu, hitBank;

  assign hitRx    = (busAddr == ADDR_W'(OFF_RX_CMD));
  assign hitTx    = (busAddr == ADDR_W'(OFF_TX_CMD));
  assign hitStat0 = (busAddr == ADDR_W'(OFF_STAT0));
  assign hitStat1 = (busAddr == ADDR_W'(OFF_STAT1));
  assign hitCpu   = (busAddr == ADDR_W'(OFF_CPU_RST));
  assign hitBank  = (busAddr == ADDR_W'(OFF_BANK));

  always_comb begin
    strobes.rxCmd  = busWrite && hitRx;
    strobes.txCmd  = busWrite && hitTx;
    strobes.desc   = busWrite ? descMatch : '0;
    strobes.stat0  = busWrite && hitStat0;
    strobes.stat1  = busWrite && hitStat1;
    strobes.cpuRst = busWrite && hitCpu;
    strobes.bank   = busWrite && hitBank;
  end

  always_comb begin
    descIdx = '0;
    for (int i = 0; i < NUM_DESC; i++) begin
      if (descMatch[i]) descIdx = DIDX_W'(i);
    end
  end

  always_comb begin
    if (|descMatch)    rdSel = RD_DESC;
    else if (hitStat0) rdSel = RD_STAT0;
    else if (hitStat1) rdSel = RD_STAT1;
    else if (hitBank)  rdSel = RD_BANK;
    else               rdSel = RD_ZERO;
  end

endmodule

// File: rtl/commRegsData.sv
module commRegsData
  import commRegsPkg::*;
#(
  parameter int DATA_W = 16,
  localparam int BYTE_W = 8,
  localparam int DIDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobes_t        strobes,
  input  rdSel_t            rdSel,
  input  logic [DIDX_W-1:0] descIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rxIrq,
  output logic              txIrq,
  output logic              cpuHold,
  output logic              ramBankHigh
);

  logic [DATA_W-1:0] descReg [NUM_DESC];
  logic [DATA_W-1:0] stat0Reg, stat1Reg;
  logic              cmdHit;

  assign cmdHit = (wrData[BYTE_W-1:0] == CMD_START);

  for (genvar g = 0; g < NUM_DESC; g++) begin : gDesc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                descReg[g] <= '0;
      else if (strobes.desc[g]) descReg[g] <= {wrData[BYTE_W-1:0], descReg[g][DATA_W-1:BYTE_W]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stat0Reg    <= '0;
      stat1Reg    <= '0;
      rxIrq       <= 1'b0;
      txIrq       <= 1'b0;
      cpuHold     <= 1'b1;
      ramBankHigh <= 1'b0;
    end else begin
      if (strobes.stat0)  stat0Reg    <= wrData;
      if (strobes.stat1)  stat1Reg    <= wrData;
      if (strobes.rxCmd)  rxIrq       <= cmdHit;
      if (strobes.txCmd)  txIrq       <= cmdHit;
      if (strobes.cpuRst) cpuHold     <= ~|wrData;
      if (strobes.bank)   ramBankHigh <= |wrData;
    end
  end

  always_comb begin
    case (rdSel)
      RD_DESC:  rdData = descReg[descIdx];
      RD_STAT0: rdData = stat0Reg;
      RD_STAT1: rdData = stat1Reg;
      RD_BANK:  rdData = DATA_W'(ramBankHigh);
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/commRegs.sv
module commRegs
  import commRegsPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int DIDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              rxIrq,
  output logic              txIrq,
  output logic              cpuHold,
  output logic              ramBankHigh
);

  wrStrobes_t        strobes;
  rdSel_t            rdSel;
  logic [DIDX_W-1:0] descIdx;

  commRegsDecode #(.ADDR_W(ADDR_W)) u_decode (
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobes  (strobes),
    .rdSel    (rdSel),
    .descIdx  (descIdx)
  );

  commRegsData #(.DATA_W(DATA_W)) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .rdSel       (rdSel),
    .descIdx     (descIdx),
    .wrData      (busWrData),
    .rdData      (busRdData),
    .rxIrq       (rxIrq),
    .txIrq       (txIrq),
    .cpuHold     (cpuHold),
    .ramBankHigh (ramBankHigh)
  );

endmodule

// File: rtl/commRegsChecker.sv
module commRegsChecker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic              rxIrq,
  input logic              txIrq,
  input logic              cpuHold,
  input logic              ramBankHigh
);

  logic wrRx, wrTx, wrCpu, wrBank, readable;

  assign wrRx   = busWrite && (busAddr == ADDR_W'('h16));
  assign wrTx   = busWrite && (busAddr == ADDR_W'('h1C));
  assign wrCpu  = busWrite && (busAddr == ADDR_W'('hC0));
  assign wrBank = busWrite && (busAddr == ADDR_W'('h60));
  assign readable = (busAddr == ADDR_W'('h40)) || (busAddr == ADDR_W'('h42)) ||
                    (busAddr == ADDR_W'('h44)) || (busAddr == ADDR_W'('h46)) ||
                    (busAddr == ADDR_W'('h60)) || (busAddr == ADDR_W'('h88)) ||
                    (busAddr == ADDR_W'('h8A));

  assert_rx_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrRx && busWrData[7:0] == 8'h8C) |=> rxIrq);
  assert_rx_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrRx && busWrData[7:0] != 8'h8C) |=> !rxIrq);
  assert_tx_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrTx && busWrData[7:0] == 8'h8C) |=> txIrq);
  assert_tx_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrTx && busWrData[7:0] != 8'h8C) |=> !txIrq);
  assert_cpu_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrCpu |=> (cpuHold == ($past(busWrData) == '0)));
  assert_bank_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrBank |=> (ramBankHigh == ($past(busWrData) != '0)));
  assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    !readable |-> (busRdData == '0));
  assert_rx_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !wrRx |=> $stable(rxIrq));
  assert_tx_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !wrTx |=> $stable(txIrq));
  assert_ctrl_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(wrCpu || wrBank) |=> ($stable(cpuHold) && $stable(ramBankHigh)));

endmodule

bind commRegs commRegsChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .busWrite    (busWrite),
  .busAddr     (busAddr),
  .busWrData   (busWrData),
  .busRdData   (busRdData),
  .rxIrq       (rxIrq),
  .txIrq       (txIrq),
  .cpuHold     (cpuHold),
  .ramBankHigh (ramBankHigh)
);

// File: tb/test_commRegs.sv
`timescale 1ns/1ps
module test_commRegs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [15:0] busWrData = 16'h0000;
  logic [15:0] busRdData;
  logic        rxIrq, txIrq, cpuHold, ramBankHigh;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  commRegs i_commRegs (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .rxIrq(rxIrq),
    .txIrq(txIrq), .cpuHold(cpuHold), .ramBankHigh(ramBankHigh)
  );

  // behavioural reference model
  int mDesc [4];
  int mStat0, mStat1, mBank, mHold, mRx, mTx;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mDesc[i]) mDesc[i] = 0;
      mStat0 = 0; mStat1 = 0; mBank = 0; mHold = 1; mRx = 0; mTx = 0;
    end else if (busWrite) begin
      case (busAddr)
        8'h16: mRx = ((busWrData % 256) == 140) ? 1 : 0;
        8'h1C: mTx = ((busWrData % 256) == 140) ? 1 : 0;
        8'h40, 8'h42, 8'h44, 8'h46:
          mDesc[(busAddr - 8'h40) / 2] = (busWrData % 256) * 256 + mDesc[(busAddr - 8'h40) / 2] / 256;
        8'h60: mBank = (busWrData != 0) ? 1 : 0;
        8'h88: mStat0 = busWrData;
        8'h8A: mStat1 = busWrData;
        8'hC0: mHold = (busWrData == 0) ? 1 : 0;
        default: ;
      endcase
    end
  end

  function automatic int modelRead(input logic [7:0] a);
    case (a)
      8'h40, 8'h42, 8'h44, 8'h46: return mDesc[(a - 8'h40) / 2];
      8'h60: return mBank;
      8'h88: return mStat0;
      8'h8A: return mStat1;
      default: return 0;
    endcase
  endfunction

  function automatic string readTag(input logic [7:0] a);
    case (a)
      8'h40, 8'h42, 8'h44, 8'h46: return "R4";
      8'h60: return "R7";
      8'h88, 8'h8A: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual 0x%0h expected 0x%0h", tag, cycles, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check("R2 R9 rxIrq", int'(rxIrq), mRx);
      check("R3 R9 txIrq", int'(txIrq), mTx);
      check("R6 R9 cpuHold", int'(cpuHold), mHold);
      check("R7 R9 ramBankHigh", int'(ramBankHigh), mBank);
      check({readTag(busAddr), " busRdData"}, int'(busRdData), modelRead(busAddr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); #1;
    busWrite = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk); #1;
    busWrite = 1'b0;
  endtask

  task automatic rdExpect(input string tag, input logic [7:0] a, input int exp);
    @(negedge clk); #1;
    busAddr = a;
    @(negedge clk);
    check(tag, int'(busRdData), exp);
  endtask

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected at most 100000", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    check("R1 cpuHold", int'(cpuHold), 1);
    check("R1 rxIrq", int'(rxIrq), 0);
    check("R1 txIrq", int'(txIrq), 0);
    check("R1 ramBankHigh", int'(ramBankHigh), 0);
    rdExpect("R1 stat0", 8'h88, 0);
    rdExpect("R1 stat1", 8'h8A, 0);
    rdExpect("R1 bank", 8'h60, 0);
    rdExpect("R1 desc", 8'h46, 0);

    // R4: byte-shift loading
    wr(8'h40, 16'h1234);
    rdExpect("R4 first byte", 8'h40, 16'h3400);
    wr(8'h40, 16'hAB56);
    rdExpect("R4 two bytes", 8'h40, 16'h5634);
    wr(8'h42, 16'h00FF); wr(8'h42, 16'h0001);
    rdExpect("R4 recv size", 8'h42, 16'h01FF);
    wr(8'h44, 16'hFF11); wr(8'h44, 16'hFF22);
    wr(8'h46, 16'h0033); wr(8'h46, 16'h0044);
    rdExpect("R4 send offset", 8'h44, 16'h2211);
    rdExpect("R4 send size", 8'h46, 16'h4433);

    // R5: status words
    wr(8'h88, 16'hBEEF); wr(8'h8A, 16'h1357);
    rdExpect("R5 stat0", 8'h88, 16'hBEEF);
    rdExpect("R5 stat1", 8'h8A, 16'h1357);

    // R2 / R3: command byte, upper byte ignored
    wr(8'h16, 16'h008C);
    check("R2 set", int'(rxIrq), 1);
    wr(8'h16, 16'h8C00);
    check("R2 clear on high byte", int'(rxIrq), 0);
    wr(8'h16, 16'h128C);
    check("R2 set with upper byte", int'(rxIrq), 1);
    wr(8'h1C, 16'h008C);
    check("R3 set", int'(txIrq), 1);
    check("R2 unaffected by send", int'(rxIrq), 1);
    wr(8'h1C, 16'h008D);
    check("R3 clear", int'(txIrq), 0);

    // R6: processor reset control
    wr(8'hC0, 16'h0005);
    check("R6 release", int'(cpuHold), 0);
    wr(8'hC0, 16'h0000);
    check("R6 hold", int'(cpuHold), 1);
    wr(8'hC0, 16'h0100);
    check("R6 release on upper bit", int'(cpuHold), 0);

    // R7: bank select
    wr(8'h60, 16'h8000);
    check("R7 upper bank", int'(ramBankHigh), 1);
    rdExpect("R7 bank read", 8'h60, 1);
    wr(8'h60, 16'h0000);
    check("R7 lower bank", int'(ramBankHigh), 0);

    // R8: holes in the map
    wr(8'h89, 16'hFFFF);
    rdExpect("R8 odd write no effect", 8'h88, 16'hBEEF);
    rdExpect("R8 odd read", 8'h89, 0);
    wr(8'h41, 16'h00AA);
    rdExpect("R8 neighbour untouched", 8'h40, 16'h5634);
    rdExpect("R8 cmd offset reads zero", 8'h16, 0);
    rdExpect("R8 cpu offset reads zero", 8'hC0, 0);
    wr(8'h50, 16'h1234);
    rdExpect("R8 hole read", 8'h50, 0);

    // mixed random traffic, compared cycle by cycle
    for (int n = 0; n < 600; n++) begin
      logic [7:0] addrs [12];
      logic [15:0] d;
      addrs = '{8'h16, 8'h1C, 8'h40, 8'h42, 8'h44, 8'h46, 8'h60, 8'h88, 8'h8A, 8'hC0, 8'h17, 8'hFE};
      d = 16'($urandom);
      if ($urandom_range(0, 3) == 0) d[7:0] = 8'h8C;
      if ($urandom_range(0, 5) == 0) d = 16'h0000;
      @(negedge clk); #1;
      busWrite = ($urandom_range(0, 1) == 1);
      busAddr = ($urandom_range(0, 7) == 0) ? 8'($urandom) : addrs[$urandom_range(0, 11)];
      busWrData = d;
    end
    @(negedge clk); #1 busWrite = 1'b0;
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule